// File: doc/BRIEF.md
# Serial Data Lane Burst Sequencer

This block carries one high-speed serial data lane through a whole burst. From the low-power stop level it walks the lane through a fixed entry handshake: a low-power request level, then a low-power bridge level, then a differential zero hold. It then shifts out a sync byte and the caller's payload bytes one bit per clock. After the last payload bit it holds the inverse of that bit as a trail. Finally it returns the lane to the stop level and keeps it there for a guard interval.

The entry, bridge, zero, trail and guard intervals are programmed in clock cycles. A programmed value of zero counts as one cycle. A separate minimum bounds the bridge and zero intervals taken together, and the zero hold is stretched when that minimum is not met. Payload arrives over a ready/valid stream with a last flag. The block takes a byte only on the first bit slot of each byte, because the lane cannot pause mid-burst.

Line state codes on `lineState`: 0 = stop (LP-11), 1 = request (LP-01), 2 = bridge (LP-00), 3 = differential zero (HS-0), 4 = differential one (HS-1), 5 = serial data.

Top module: `dlane_burst_seq`

## Requirements
- R1: During and after reset, with no request, `lineState` is 0, `serBit` is 0 and `inReady` is 0.
- R2: A `burstReq` sampled high in idle starts the burst on the next cycle with code 1 for max(durLpx,1) cycles, `serBit` 0.
- R3: Code 2 follows for max(durPrepare,1) cycles, `serBit` 0.
- R4: Code 3 follows with `serBit` 0 for max(max(durZero,1), durPrepZeroMin − max(durPrepare,1)) cycles.
- R5: The sync byte 8'b00011101 follows under code 5, least significant bit first on `serBit`, one bit per cycle.
- R6: Payload bytes follow under code 5 back to back, least significant bit first. `inReady` is high only on the first bit slot of a byte in the data phase, where that bit is `inData[0]`. The byte taken with `inLast` high is the final one.
- R7: After the final payload bit the lane holds code 4 with `serBit` 1 if that bit was 0, or code 3 with `serBit` 0 if it was 1, for max(durTrail,1) cycles.
- R8: If `inValid` is low when `inReady` is high, no bit is sent in that slot. That slot and max(durTrail,1) further cycles carry the trail for the last bit sent; with no payload that bit is the sync byte's final 0.
- R9: After the trail the lane shows code 0 for max(durExit,1) cycles before idle. A request raised in that interval is kept, and the next code 1 appears after exactly max(durExit,1)+1 cycles of code 0.
- R10: A `burstReq` raised while a burst is between its first code 1 cycle and its last trail cycle is dropped; no second burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstReq | input | 1 | Burst request |
| inData | input | BYTE_W | Payload byte |
| inValid | input | 1 | Payload byte valid |
| inLast | input | 1 | Marks final payload byte |
| inReady | output | 1 | Byte taken this cycle if valid |
| durLpx | input | DUR_W | Request-level interval, cycles |
| durPrepare | input | DUR_W | Bridge-level interval, cycles |
| durZero | input | DUR_W | Differential zero interval, cycles |
| durPrepZeroMin | input | DUR_W | Minimum of bridge plus zero, cycles |
| durTrail | input | DUR_W | Trail interval, cycles |
| durExit | input | DUR_W | Stop guard interval, cycles |
| lineState | output | 3 | Encoded line state |
| serBit | output | 1 | Serial bit / differential polarity |

## Verification
The bench builds the block with its defaults: 8-bit duration fields and 8-bit bytes. With those values every interval the bench programs, 0 to 30 cycles, fits without wrap. Programming zeros exercises the one-cycle floor. A combined minimum well above bridge plus zero forces the zero hold to stretch. Payloads of one to six bytes, ending in either bit value, give both trail polarities. Streams that drop valid give both the empty-burst underrun and the mid-payload underrun.

// File: rtl/dlane_pkg.sv
package dlane_pkg;

  typedef enum logic [2:0] {
    LINE_STOP   = 3'd0,
    LINE_LP01   = 3'd1,
    LINE_LP00   = 3'd2,
    LINE_HS0    = 3'd3,
    LINE_HS1    = 3'd4,
    LINE_HSDATA = 3'd5
  } lineState_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LPX,
    S_PREP,
    S_ZERO,
    S_SYNC,
    S_DATA,
    S_TRAIL,
    S_EXIT
  } seqState_e;

  // strobes from sequencing control to the bit shifter
  typedef struct packed {
    logic loadSync;
    logic shiftEn;
    logic takeByte;
  } dpCtl_t;

endpackage

// File: rtl/dlane_shift.sv
module dlane_shift
  import dlane_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_PATTERN = 8'b00011101
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              hsBit,
  output logic              lastBit,
  output logic              byteStart,
  output logic              byteEnd,
  output logic              lastFlag
);

  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  bitCntInc;

  always_comb begin
    bitCntInc = (bitCnt == CNT_TOP) ? '0 : bitCnt + 1'b1;
    byteStart = (bitCnt == '0);
    byteEnd   = (bitCnt == CNT_TOP);
    hsBit     = ctl.takeByte ? inData[0] : shReg[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      lastBit  <= 1'b0;
      lastFlag <= 1'b0;
    end else if (ctl.loadSync) begin
      shReg    <= SYNC_PATTERN;
      bitCnt   <= '0;
      lastFlag <= 1'b0;
    end else if (ctl.takeByte) begin
      shReg    <= {1'b0, inData[BYTE_W-1:1]};
      bitCnt   <= bitCntInc;
      lastBit  <= inData[0];
      lastFlag <= inLast;
    end else if (ctl.shiftEn) begin
      shReg    <= {1'b0, shReg[BYTE_W-1:1]};
      bitCnt   <= bitCntInc;
      lastBit  <= shReg[0];
    end
  end

  // a full byte of shifting always lands back on the first bit slot
  assert_byte_wrap_R6 : assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.shiftEn || ctl.takeByte) && byteEnd) |=> byteStart);

endmodule

// File: rtl/dlane_ctrl.sv
module dlane_ctrl
  import dlane_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstReq,
  input  logic             inValid,
  input  logic             byteStart,
  input  logic             byteEnd,
  input  logic             lastFlag,
  input  logic             hsBit,
  input  logic             lastBit,
  input  logic [DUR_W-1:0] durLpx,
  input  logic [DUR_W-1:0] durPrepare,
  input  logic [DUR_W-1:0] durZero,
  input  logic [DUR_W-1:0] durPrepZeroMin,
  input  logic [DUR_W-1:0] durTrail,
  input  logic [DUR_W-1:0] durExit,
  output dpCtl_t           ctl,
  output logic             inReady,
  output lineState_e       lineState,
  output logic             serBit
);

  localparam int LIM_W = DUR_W + 1;

  function automatic logic [LIM_W-1:0] atLeastOne(input logic [DUR_W-1:0] d);
    return (d == '0) ? LIM_W'(1) : LIM_W'(d);
  endfunction

  seqState_e        st, stNext;
  logic [LIM_W-1:0] cnt, curLim, prepLen, zeroNeed, zeroLen;
  logic             timerDone, timed, underrun, pendReq;

  // zero hold is stretched until bridge plus zero meets the combined minimum
  always_comb begin
    prepLen  = atLeastOne(durPrepare);
    zeroNeed = (LIM_W'(durPrepZeroMin) > prepLen) ? LIM_W'(durPrepZeroMin) - prepLen : '0;
    zeroLen  = (zeroNeed > atLeastOne(durZero)) ? zeroNeed : atLeastOne(durZero);
    unique case (st)
      S_LPX:   curLim = atLeastOne(durLpx);
      S_PREP:  curLim = prepLen;
      S_ZERO:  curLim = zeroLen;
      S_TRAIL: curLim = atLeastOne(durTrail);
      S_EXIT:  curLim = atLeastOne(durExit);
      default: curLim = LIM_W'(1);
    endcase
    timed     = (st == S_LPX) || (st == S_PREP) || (st == S_ZERO) ||
                (st == S_TRAIL) || (st == S_EXIT);
    timerDone = (cnt + LIM_W'(1)) >= curLim;
  end

  always_comb begin
    inReady      = (st == S_DATA) && byteStart;
    underrun     = inReady && !inValid;
    ctl.loadSync = (st == S_ZERO) && timerDone;
    ctl.takeByte = inReady && inValid;
    ctl.shiftEn  = (st == S_SYNC) || ((st == S_DATA) && !byteStart);
  end

  always_comb begin
    stNext = st;
    unique case (st)
      S_IDLE:  if (burstReq || pendReq) stNext = S_LPX;
      S_LPX:   if (timerDone) stNext = S_PREP;
      S_PREP:  if (timerDone) stNext = S_ZERO;
      S_ZERO:  if (timerDone) stNext = S_SYNC;
      S_SYNC:  if (byteEnd) stNext = S_DATA;
      S_DATA:  if (underrun || (byteEnd && lastFlag)) stNext = S_TRAIL;
      S_TRAIL: if (timerDone) stNext = S_EXIT;
      S_EXIT:  if (timerDone) stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      cnt     <= '0;
      pendReq <= 1'b0;
    end else begin
      st      <= stNext;
      cnt     <= (stNext != st || !timed) ? '0 : cnt + LIM_W'(1);
      pendReq <= (st == S_EXIT) ? (pendReq | burstReq) : 1'b0;
    end
  end

  always_comb begin
    lineState = LINE_STOP;
    serBit    = 1'b0;
    unique case (st)
      S_LPX:  lineState = LINE_LP01;
      S_PREP: lineState = LINE_LP00;
      S_ZERO: lineState = LINE_HS0;
      S_SYNC: begin
        lineState = LINE_HSDATA;
        serBit    = hsBit;
      end
      S_DATA: begin
        if (underrun) begin
          lineState = lastBit ? LINE_HS0 : LINE_HS1;
          serBit    = ~lastBit;
        end else begin
          lineState = LINE_HSDATA;
          serBit    = hsBit;
        end
      end
      S_TRAIL: begin
        lineState = lastBit ? LINE_HS0 : LINE_HS1;
        serBit    = ~lastBit;
      end
      default: ;
    endcase
  end

  assert_lpx_from_idle_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (st == S_LPX && $past(st) != S_LPX) |-> ($past(st) == S_IDLE));

  assert_prep_after_lpx_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PREP && $past(st) != S_PREP) |-> ($past(st) == S_LPX));

  assert_data_after_sync_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DATA && $past(st) == S_SYNC) |-> byteStart);

  assert_trail_after_payload_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (st == S_TRAIL && $past(st) != S_TRAIL) |-> ($past(st) == S_DATA));

  assert_exit_after_trail_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (st == S_EXIT && $past(st) != S_EXIT) |-> ($past(st) == S_TRAIL));

endmodule

// File: rtl/dlane_burst_seq.sv
module dlane_burst_seq
  import dlane_pkg::*;
#(
  parameter int DUR_W  = 8,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_PATTERN = 8'b00011101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstReq,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  input  logic [DUR_W-1:0]  durLpx,
  input  logic [DUR_W-1:0]  durPrepare,
  input  logic [DUR_W-1:0]  durZero,
  input  logic [DUR_W-1:0]  durPrepZeroMin,
  input  logic [DUR_W-1:0]  durTrail,
  input  logic [DUR_W-1:0]  durExit,
  output logic [2:0]        lineState,
  output logic              serBit
);

  dpCtl_t     ctl;
  lineState_e lineEnc;
  logic       hsBit, lastBit, byteStart, byteEnd, lastFlag;

  dlane_ctrl #(.DUR_W(DUR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .burstReq(burstReq), .inValid(inValid),
    .byteStart(byteStart), .byteEnd(byteEnd), .lastFlag(lastFlag),
    .hsBit(hsBit), .lastBit(lastBit),
    .durLpx(durLpx), .durPrepare(durPrepare), .durZero(durZero),
    .durPrepZeroMin(durPrepZeroMin), .durTrail(durTrail), .durExit(durExit),
    .ctl(ctl), .inReady(inReady), .lineState(lineEnc), .serBit(serBit)
  );

  dlane_shift #(.BYTE_W(BYTE_W), .SYNC_PATTERN(SYNC_PATTERN)) uShift (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inLast(inLast),
    .hsBit(hsBit), .lastBit(lastBit), .byteStart(byteStart),
    .byteEnd(byteEnd), .lastFlag(lastFlag)
  );

  assign lineState = lineEnc;

endmodule

// File: tb/tb_dlane_burst_seq.sv
`timescale 1ns/1ps
module tb_dlane_burst_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       burstReq = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic [7:0] durLpx = '0, durPrepare = '0, durZero = '0;
  logic [7:0] durPrepZeroMin = '0, durTrail = '0, durExit = '0;
  logic [2:0] lineState;
  logic       serBit;

  always #5 clk = ~clk;

  dlane_burst_seq dut (
    .clk(clk), .rstN(rstN), .burstReq(burstReq), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .durLpx(durLpx), .durPrepare(durPrepare), .durZero(durZero),
    .durPrepZeroMin(durPrepZeroMin), .durTrail(durTrail), .durExit(durExit),
    .lineState(lineState), .serBit(serBit)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  logic [7:0] payload [0:15];
  int nBytes;
  bit underrunMode;
  int expLs [0:599];
  int expBit [0:599];
  int expTag [0:599];
  int expN;
  int gotLs [0:599];
  int gotBit [0:599];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string reqName(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int lim1(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int zeroLenOf(input int p, input int z, input int m);
    int need = m - lim1(p);
    return (need > lim1(z)) ? need : lim1(z);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic pushExp(input int ls, input int b, input int tag);
    expLs[expN] = ls; expBit[expN] = b; expTag[expN] = tag; expN++;
  endtask

  task automatic buildExp();
    int last = 0;
    expN = 0;
    for (int i = 0; i < lim1(int'(durLpx)); i++) pushExp(1, 0, 2);
    for (int i = 0; i < lim1(int'(durPrepare)); i++) pushExp(2, 0, 3);
    for (int i = 0; i < zeroLenOf(int'(durPrepare), int'(durZero), int'(durPrepZeroMin)); i++)
      pushExp(3, 0, 4);
    for (int i = 0; i < 8; i++) begin
      last = (8'b00011101 >> i) & 1;
      pushExp(5, last, 5);
    end
    for (int k = 0; k < nBytes; k++)
      for (int i = 0; i < 8; i++) begin
        last = (payload[k] >> i) & 1;
        pushExp(5, last, 6);
      end
    if (underrunMode) pushExp(last ? 3 : 4, last ? 0 : 1, 8);
    for (int i = 0; i < lim1(int'(durTrail)); i++)
      pushExp(last ? 3 : 4, last ? 0 : 1, underrunMode ? 8 : 7);
  endtask

  // mode: 0 plain, 1 request during burst, 2 request during exit interval
  task automatic runBurst(input int lpx, input int prep, input int zero, input int pzm,
                          input int trail, input int ext, input int mode);
    int n = 0, idx = 0, acc = 0, pokeAt, stopCnt;
    bit accPrev = 0;
    int bad [2:8];
    int firstAct [2:8];
    int firstExp [2:8];
    bit seen [2:8];
    @(negedge clk);
    durLpx = 8'(lpx); durPrepare = 8'(prep); durZero = 8'(zero);
    durPrepZeroMin = 8'(pzm); durTrail = 8'(trail); durExit = 8'(ext);
    buildExp();
    for (int t = 2; t <= 8; t++) begin bad[t] = 0; seen[t] = 0; firstAct[t] = 0; firstExp[t] = 0; end
    pokeAt = (mode == 1) ? lim1(lpx) : -1;
    burstReq = 1'b1;
    @(negedge clk);
    burstReq = 1'b0;
    forever begin
      if (accPrev) idx++;
      inData  = (idx < nBytes) ? payload[idx] : 8'($urandom_range(0, 255));
      inValid = (idx < nBytes);
      inLast  = !underrunMode && (idx == nBytes - 1);
      burstReq = (n == pokeAt);
      #1;
      accPrev = inReady && inValid;
      if (accPrev) acc++;
      if (lineState == 3'd0) break;
      gotLs[n] = int'(lineState); gotBit[n] = int'(serBit);
      n++;
      if (n >= 590) break;
      @(negedge clk);
    end
    burstReq = 1'b0;
    inValid = 1'b0;
    inLast = 1'b0;
    for (int i = 0; i < n && i < expN; i++) begin
      int t = expTag[i];
      seen[t] = 1;
      if (gotLs[i] != expLs[i] || gotBit[i] != expBit[i]) begin
        if (bad[t] == 0) begin
          firstAct[t] = gotLs[i] * 10 + gotBit[i];
          firstExp[t] = expLs[i] * 10 + expBit[i];
        end
        bad[t]++;
      end
    end
    for (int t = 2; t <= 8; t++)
      if (seen[t]) check(bad[t] == 0, reqName(t), firstAct[t], firstExp[t]);
    check(n == expN, underrunMode ? "R8" : "R7", n, expN);
    check(acc == nBytes, "R6", acc, nBytes);
    if (mode == 2) begin
      burstReq = 1'b1;
      stopCnt = 1;
      @(negedge clk);
      burstReq = 1'b0;
      while (lineState == 3'd0 && stopCnt < 600) begin
        stopCnt++;
        @(negedge clk);
      end
      check(lineState == 3'd1 && stopCnt == lim1(ext) + 1, "R9", stopCnt, lim1(ext) + 1);
      while (lineState != 3'd0) @(negedge clk);
      repeat (lim1(ext) + 2) @(negedge clk);
    end else if (mode == 1) begin
      int nonStop = 0;
      repeat (lim1(ext) + 8) begin
        @(negedge clk);
        if (lineState != 3'd0) nonStop++;
      end
      check(nonStop == 0, "R10", nonStop, 0);
    end else begin
      repeat (lim1(ext) + 1) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(lineState == 3'd0 && serBit == 1'b0 && inReady == 1'b0, "R1",
          int'(lineState), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(lineState == 3'd0 && serBit == 1'b0 && inReady == 1'b0, "R1",
          int'(lineState), 0);

    // all intervals programmed to zero: one-cycle floor, single byte ending in 1 (R7 HS-0 trail)
    nBytes = 1; underrunMode = 0; payload[0] = 8'hA5;
    runBurst(0, 0, 0, 0, 0, 0, 0);
    // last bit 0 gives HS-1 trail; combined minimum stretches the zero hold (R4)
    nBytes = 2; payload[0] = 8'h3C; payload[1] = 8'h7F;
    runBurst(3, 2, 1, 20, 4, 2, 0);
    // empty burst: valid never raised, trail follows sync final 0 (R8)
    nBytes = 0; underrunMode = 1;
    runBurst(2, 3, 4, 0, 2, 3, 0);
    // mid-payload underrun after two bytes (R8)
    nBytes = 2; payload[0] = 8'hFF; payload[1] = 8'h80;
    runBurst(1, 1, 5, 3, 3, 1, 0);
    // request during the bridge level is dropped (R10)
    nBytes = 1; underrunMode = 0; payload[0] = 8'h01;
    runBurst(2, 2, 2, 0, 2, 3, 1);
    // request during exit is held (R9), short and longer guard
    nBytes = 1; payload[0] = 8'h55;
    runBurst(1, 1, 1, 0, 1, 1, 2);
    nBytes = 1; payload[0] = 8'hC3;
    runBurst(2, 1, 3, 0, 2, 7, 2);

    for (int r = 0; r < 10; r++) begin
      nBytes = $urandom_range(1, 6);
      underrunMode = ($urandom_range(0, 3) == 0);
      for (int k = 0; k < nBytes; k++) payload[k] = 8'($urandom_range(0, 255));
      runBurst($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12),
               $urandom_range(0, 30), $urandom_range(0, 12), $urandom_range(0, 12), 0);
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule